// File: doc/BRIEF.md
# Dual-Accumulator DSP Arithmetic Unit

This block is the arithmetic stage of a small signal-processing core. It holds two 16-bit accumulators, A and B, and a six-bit flag set for each. On every cycle in which `op_valid` is high, it takes one operation code and an accumulator select. The selected accumulator supplies the Q operand and receives the result. A two-bit source select picks the P operand from one of four words: a data-RAM read word, the internal transfer bus, or the high or low half of the multiplier output. The bus word is sampled in the same cycle it is presented. Any transfer onto the bus is therefore complete before the unit reads P.

Results and flags are registered and appear one clock after the request. Multi-word arithmetic is chained through the carry-in. The add-with-carry, subtract-with-borrow and rotate-left operations take their carry from the *other* accumulator's carry flag. The second overflow flag toggles on every overflow, so it keeps a record of overflow history. The second sign flag then records which way the last overflow went.

Top module: `dsp_dual_acc_alu`

## Requirements
- R1: While `rst_n` is low, both accumulators and both flag sets are cleared to zero.
- R2: A cycle with `op_valid` low, or with operation code 0, leaves both accumulators and both flag sets unchanged.
- R3: `acc_sel` = 0 makes A the Q operand and destination, and `acc_sel` = 1 does the same for B. The accumulator that is not selected keeps its value and its flags.
- R4: `p_sel` chooses P as follows: 0 takes `ram_word`, 1 takes `bus_word`, 2 takes `mul_hi` and 3 takes `mul_lo`.
- R5: The bitwise and rearranging operations are: 1 OR, 2 AND, 3 XOR, 10 one's complement of Q, 13 Q shifted left by 2, 14 Q shifted left by 4, and 15 swap of the two bytes of Q.
- R6: The arithmetic operations are: 4 SUB (Q−P), 5 ADD (Q+P), 8 DEC (Q−1) and 9 INC (Q+1). C is the unsigned carry out of the 16-bit add, or the borrow of the subtract.
- R7: Operation 7 (Q+P+cin) and operation 6 (Q−P−cin) take cin from the carry flag of the accumulator that is not selected. C is the full carry or borrow, including cin.
- R8: Operation 11 is an arithmetic right shift by one that keeps bit 15, and C becomes old bit 0. Operation 12 shifts left by one, puts the other accumulator's carry into bit 0, and C becomes old bit 15. Both clear OV0 and OV1.
- R9: Flags read as {S1,S0,C,Z,OV1,OV0}, from bit 5 down to bit 0. After any operation from 1 to 15, S0 equals result bit 15, and Z is 1 exactly when the 16-bit result is zero.
- R10: Operations 1, 2, 3, 10, 13, 14 and 15 clear C, OV0 and OV1, and leave S1 unchanged.
- R11: For ADD, ADC and INC, OV0 is 1 when Q and P have the same sign and the result sign differs from Q. For SUB, SBB and DEC, OV0 is 1 when Q and P differ in sign and the result sign differs from Q. INC and DEC use P = 1.
- R12: For operations 4 to 9, when OV0 is 1, S1 becomes old OV1 XOR (NOT result bit 15) and OV1 inverts. When OV0 is 0, S1 and OV1 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute the presented operation this cycle |
| acc_sel | input | 1 | 0 selects A, 1 selects B |
| p_sel | input | 2 | P operand source select |
| opcode | input | 4 | Operation code |
| ram_word | input | 16 | Data-RAM read word |
| bus_word | input | 16 | Internal transfer bus word |
| mul_hi | input | 16 | Multiplier high word |
| mul_lo | input | 16 | Multiplier low word |
| acc_a | output | 16 | Accumulator A |
| acc_b | output | 16 | Accumulator B |
| flags_a | output | 6 | Flags of A, {S1,S0,C,Z,OV1,OV0} |
| flags_b | output | 6 | Flags of B, {S1,S0,C,Z,OV1,OV0} |

## Verification
The hardest state to reach is the overflow history of R12. S1 only moves when OV0 fires, so the stimulus first has to produce one signed overflow and then a second one in the opposite direction. It does this by adding 0x0001 to 0x7FFF and then adding 0x8000 twice. The cross-accumulator carry of R7 also needs set-up. B is first loaded by an OR from the bus and shifted right so that its carry is 1. Only then does A run ADC, SBB and the rotate-left. After these directed sequences, a long run of random operations is compared against the bench's own model on every clock.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    localparam int OP_W    = 4;
    localparam int PSEL_W  = 2;
    localparam int NUM_ACC = 2;
    localparam int FLAG_W  = 6;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,  OP_OR   = 4'd1,  OP_AND  = 4'd2,  OP_XOR  = 4'd3,
        OP_SUB  = 4'd4,  OP_ADD  = 4'd5,  OP_SBB  = 4'd6,  OP_ADC  = 4'd7,
        OP_DEC  = 4'd8,  OP_INC  = 4'd9,  OP_NOT  = 4'd10, OP_SHR1 = 4'd11,
        OP_SHL1 = 4'd12, OP_SHL2 = 4'd13, OP_SHL4 = 4'd14, OP_SWAP = 4'd15
    } alu_op_e;

    typedef enum logic [PSEL_W-1:0] {
        PSRC_RAM = 2'd0,
        PSRC_BUS = 2'd1,
        PSRC_MHI = 2'd2,
        PSRC_MLO = 2'd3
    } psrc_e;

    typedef struct packed {
        logic s1;
        logic s0;
        logic c;
        logic z;
        logic ov1;
        logic ov0;
    } acc_flags_t;
endpackage

// File: rtl/dacc_p_mux.sv
module dacc_p_mux
    import dacc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  psrc_e             sel,
    input  logic [DATA_W-1:0] ram_word,
    input  logic [DATA_W-1:0] bus_word,
    input  logic [DATA_W-1:0] mul_hi,
    input  logic [DATA_W-1:0] mul_lo,
    output logic [DATA_W-1:0] p_word
);
    always_comb begin
        unique case (sel)
            PSRC_RAM: p_word = ram_word;
            PSRC_BUS: p_word = bus_word;
            PSRC_MHI: p_word = mul_hi;
            PSRC_MLO: p_word = mul_lo;
        endcase
    end
endmodule

// File: rtl/dacc_alu_core.sv
module dacc_alu_core
    import dacc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] q,
    input  logic [DATA_W-1:0] p,
    input  logic              cin,
    input  acc_flags_t        f_in,
    output logic [DATA_W-1:0] r,
    output acc_flags_t        f_out
);
    localparam int MSB  = DATA_W - 1;
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] p_eff;
    logic              cin_eff;
    logic [DATA_W:0]   add_w;
    logic [DATA_W:0]   sub_w;
    logic              is_add, is_sub;
    logic              ov_now;

    always_comb begin
        is_add  = (op == OP_ADD) || (op == OP_ADC) || (op == OP_INC);
        is_sub  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC);
        p_eff   = ((op == OP_INC) || (op == OP_DEC)) ? DATA_W'(1) : p;
        cin_eff = ((op == OP_ADC) || (op == OP_SBB)) ? cin : 1'b0;
        add_w   = {1'b0, q} + {1'b0, p_eff} + {{DATA_W{1'b0}}, cin_eff};
        sub_w   = {1'b0, q} - {1'b0, p_eff} - {{DATA_W{1'b0}}, cin_eff};
    end

    always_comb begin
        unique case (op)
            OP_NOP:  r = q;
            OP_OR:   r = q | p;
            OP_AND:  r = q & p;
            OP_XOR:  r = q ^ p;
            OP_SUB,
            OP_SBB,
            OP_DEC:  r = sub_w[DATA_W-1:0];
            OP_ADD,
            OP_ADC,
            OP_INC:  r = add_w[DATA_W-1:0];
            OP_NOT:  r = ~q;
            OP_SHR1: r = {q[MSB], q[MSB:1]};
            OP_SHL1: r = {q[MSB-1:0], cin};
            OP_SHL2: r = q << 2;
            OP_SHL4: r = q << 4;
            OP_SWAP: r = {q[HALF-1:0], q[DATA_W-1:HALF]};
        endcase
    end

    always_comb begin
        ov_now = 1'b0;
        if (is_add)
            ov_now = (q[MSB] == p_eff[MSB]) && (r[MSB] != q[MSB]);
        else if (is_sub)
            ov_now = (q[MSB] != p_eff[MSB]) && (r[MSB] != q[MSB]);
    end

    always_comb begin
        f_out    = f_in;
        f_out.s0 = r[MSB];
        f_out.z  = (r == '0);
        if (is_add || is_sub) begin
            f_out.c   = is_add ? add_w[DATA_W] : sub_w[DATA_W];
            f_out.ov0 = ov_now;
            if (ov_now) begin
                f_out.s1  = f_in.ov1 ^ ~r[MSB];
                f_out.ov1 = ~f_in.ov1;
            end
        end else if (op == OP_SHR1) begin
            f_out.c   = q[0];
            f_out.ov0 = 1'b0;
            f_out.ov1 = 1'b0;
        end else if (op == OP_SHL1) begin
            f_out.c   = q[MSB];
            f_out.ov0 = 1'b0;
            f_out.ov1 = 1'b0;
        end else if (op != OP_NOP) begin
            f_out.c   = 1'b0;
            f_out.ov0 = 1'b0;
            f_out.ov1 = 1'b0;
        end
    end
endmodule

// File: rtl/dacc_acc_bank.sv
module dacc_acc_bank
    import dacc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_ACC-1:0]               wr_en,
    input  logic [DATA_W-1:0]                wr_val,
    input  acc_flags_t                       wr_flags,
    output logic [NUM_ACC-1:0][DATA_W-1:0]   acc_q,
    output acc_flags_t [NUM_ACC-1:0]         flags_q
);
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[g]   <= '0;
                flags_q[g] <= '0;
            end else if (wr_en[g]) begin
                acc_q[g]   <= wr_val;
                flags_q[g] <= wr_flags;
            end
        end
    end
endmodule

// File: rtl/dsp_dual_acc_alu.sv
module dsp_dual_acc_alu
    import dacc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              acc_sel,
    input  logic [1:0]        p_sel,
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] ram_word,
    input  logic [DATA_W-1:0] bus_word,
    input  logic [DATA_W-1:0] mul_hi,
    input  logic [DATA_W-1:0] mul_lo,
    output logic [DATA_W-1:0] acc_a,
    output logic [DATA_W-1:0] acc_b,
    output logic [5:0]        flags_a,
    output logic [5:0]        flags_b
);
    logic [NUM_ACC-1:0][DATA_W-1:0] acc_q;
    acc_flags_t [NUM_ACC-1:0]       flg_q;
    logic [DATA_W-1:0]              p_word, q_word, r_word;
    acc_flags_t                     f_next;
    alu_op_e                        op;
    logic                           do_exec;
    logic [NUM_ACC-1:0]             wr_en;

    assign op      = alu_op_e'(opcode);
    assign q_word  = acc_q[acc_sel];
    assign do_exec = op_valid && (op != OP_NOP);
    assign wr_en   = {do_exec && acc_sel, do_exec && !acc_sel};

    dacc_p_mux #(.DATA_W(DATA_W)) u_pmux (
        .sel      (psrc_e'(p_sel)),
        .ram_word (ram_word),
        .bus_word (bus_word),
        .mul_hi   (mul_hi),
        .mul_lo   (mul_lo),
        .p_word   (p_word)
    );

    dacc_alu_core #(.DATA_W(DATA_W)) u_core (
        .op    (op),
        .q     (q_word),
        .p     (p_word),
        .cin   (flg_q[~acc_sel].c),
        .f_in  (flg_q[acc_sel]),
        .r     (r_word),
        .f_out (f_next)
    );

    dacc_acc_bank #(.DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_val   (r_word),
        .wr_flags (f_next),
        .acc_q    (acc_q),
        .flags_q  (flg_q)
    );

    assign acc_a   = acc_q[0];
    assign acc_b   = acc_q[1];
    assign flags_a = flg_q[0];
    assign flags_b = flg_q[1];
endmodule

// File: rtl/dsp_dual_acc_alu_chk.sv
module dsp_dual_acc_alu_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              acc_sel,
    input logic [3:0]        opcode,
    input logic [DATA_W-1:0] acc_a,
    input logic [DATA_W-1:0] acc_b,
    input logic [5:0]        flags_a,
    input logic [5:0]        flags_b
);
    logic idle, arith, clearing;
    assign idle     = !op_valid || (opcode == 4'd0);
    assign arith    = (opcode >= 4'd4) && (opcode <= 4'd9);
    assign clearing = (opcode inside {4'd1, 4'd2, 4'd3, 4'd10, 4'd13, 4'd14, 4'd15});

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (acc_a == $past(acc_a)) && (acc_b == $past(acc_b)) &&
                 (flags_a == $past(flags_a)) && (flags_b == $past(flags_b)));

    p_b_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel) |=> (acc_b == $past(acc_b)) && (flags_b == $past(flags_b)));

    p_a_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && acc_sel) |=> (acc_a == $past(acc_a)) && (flags_a == $past(flags_a)));

    p_zero_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel && !idle) |=>
            (flags_a[2] == (acc_a == '0)) && (flags_a[4] == acc_a[DATA_W-1]));

    p_logic_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && acc_sel && clearing) |=>
            (flags_b[3] == 1'b0) && (flags_b[1:0] == 2'b00) && (flags_b[5] == $past(flags_b[5])));

    p_ov_history_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel && arith) |=> (flags_a[0] == (flags_a[1] != $past(flags_a[1]))));
endmodule

bind dsp_dual_acc_alu dsp_dual_acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_valid(op_valid),
    .acc_sel (acc_sel),
    .opcode  (opcode),
    .acc_a   (acc_a),
    .acc_b   (acc_b),
    .flags_a (flags_a),
    .flags_b (flags_b)
);

// File: tb/test_dsp_dual_acc_alu.sv
module test_dsp_dual_acc_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic        acc_sel;
    logic [1:0]  p_sel;
    logic [3:0]  opcode;
    logic [15:0] ram_word, bus_word, mul_hi, mul_lo;
    logic [15:0] acc_a, acc_b;
    logic [5:0]  flags_a, flags_b;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] ma, mb;
    logic [5:0]  mfa, mfb;

    always #5 clk = ~clk;

    dsp_dual_acc_alu i_dsp_dual_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .acc_sel(acc_sel),
        .p_sel(p_sel), .opcode(opcode), .ram_word(ram_word), .bus_word(bus_word),
        .mul_hi(mul_hi), .mul_lo(mul_lo), .acc_a(acc_a), .acc_b(acc_b),
        .flags_a(flags_a), .flags_b(flags_b)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0:                                   return "R2";
            4'd1, 4'd2, 4'd3, 4'd10, 4'd13, 4'd14, 4'd15: return "R5/R10";
            4'd4, 4'd5, 4'd8, 4'd9:                 return "R6/R11/R12";
            4'd6, 4'd7:                             return "R7/R11/R12";
            default:                                return "R8";
        endcase
    endfunction

    // Behavioural reference of one operation (flags {S1,S0,C,Z,OV1,OV0})
    function automatic void ref_op(input logic [3:0] op, input logic [15:0] q, input logic [15:0] p_in,
                                   input bit cin, input logic [5:0] fi,
                                   output logic [15:0] r, output logic [5:0] fo);
        int qi, pi, ri;
        bit is_add, is_sub, ov;
        logic [15:0] pv;
        qi = int'(q); pv = p_in; is_add = 0; is_sub = 0; ov = 0; fo = fi; ri = 0;
        if (op == 4'd8 || op == 4'd9) pv = 16'd1;
        pi = int'(pv);
        case (op)
            4'd1:  ri = int'(q | pv);
            4'd2:  ri = int'(q & pv);
            4'd3:  ri = int'(q ^ pv);
            4'd4, 4'd8: begin ri = qi - pi; is_sub = 1; end
            4'd6:  begin ri = qi - pi - int'(cin); is_sub = 1; end
            4'd5, 4'd9: begin ri = qi + pi; is_add = 1; end
            4'd7:  begin ri = qi + pi + int'(cin); is_add = 1; end
            4'd10: ri = int'(~q);
            4'd11: ri = (qi / 2) + (q[15] ? 32768 : 0);
            4'd12: ri = (qi * 2) + int'(cin);
            4'd13: ri = qi * 4;
            4'd14: ri = qi * 16;
            4'd15: ri = (qi % 256) * 256 + qi / 256;
            default: ri = qi;
        endcase
        r = ri[15:0];
        if (op == 4'd0) return;
        fo[4] = r[15];
        fo[2] = (r == 16'd0);
        if (is_add || is_sub) begin
            fo[3] = is_add ? (ri > 65535) : (ri < 0);
            if (is_add) ov = (q[15] == pv[15]) && (r[15] != q[15]);
            else        ov = (q[15] != pv[15]) && (r[15] != q[15]);
            fo[0] = ov;
            if (ov) begin
                fo[5] = fi[1] ^ ~r[15];
                fo[1] = ~fi[1];
            end
        end else begin
            fo[3] = (op == 4'd11) ? q[0] : (op == 4'd12) ? q[15] : 1'b0;
            fo[1] = 1'b0;
            fo[0] = 1'b0;
        end
    endfunction

    task automatic check16(input string tag, input string nm, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check16(tag, "acc_a", acc_a, ma);
        check16(tag, "acc_b", acc_b, mb);
        check16(tag, "flags_a", {10'd0, flags_a}, {10'd0, mfa});
        check16(tag, "flags_b", {10'd0, flags_b}, {10'd0, mfb});
    endtask

    // Present one request, advance the model, compare one clock later at negedge
    task automatic step(input bit v, input bit sel, input logic [1:0] ps, input logic [3:0] op,
                        input logic [15:0] ram, input logic [15:0] bus, input logic [15:0] hi,
                        input logic [15:0] lo);
        logic [15:0] pv, r;
        logic [5:0]  fo;
        op_valid = v; acc_sel = sel; p_sel = ps; opcode = op;
        ram_word = ram; bus_word = bus; mul_hi = hi; mul_lo = lo;
        case (ps)
            2'd0: pv = ram;
            2'd1: pv = bus;
            2'd2: pv = hi;
            default: pv = lo;
        endcase
        if (v && op != 4'd0) begin
            if (!sel) begin
                ref_op(op, ma, pv, mfb[3], mfa, r, fo); ma = r; mfa = fo;
            end else begin
                ref_op(op, mb, pv, mfa[3], mfb, r, fo); mb = r; mfb = fo;
            end
        end
        @(negedge clk);
        compare_all(v ? tag_of(op) : "R2");
    endtask

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b1; acc_sel = 1'b0; p_sel = 2'd1; opcode = 4'd5;
        ram_word = 16'h1234; bus_word = 16'h5555; mul_hi = 16'h0; mul_lo = 16'h0;
        ma = '0; mb = '0; mfa = '0; mfb = '0;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;

        // R4: each P source, distinct words, ADD into A from zero
        step(1, 0, 2'd0, 4'd5, 16'h0011, 16'h0022, 16'h0044, 16'h0088);
        step(1, 0, 2'd1, 4'd5, 16'h0011, 16'h0022, 16'h0044, 16'h0088);
        step(1, 0, 2'd2, 4'd5, 16'h0011, 16'h0022, 16'h0044, 16'h0088);
        step(1, 0, 2'd3, 4'd5, 16'h0011, 16'h0022, 16'h0044, 16'h0088);
        // R2: idle and opcode 0 leave everything
        step(0, 0, 2'd1, 4'd9, 0, 16'hFFFF, 0, 0);
        step(1, 1, 2'd1, 4'd0, 0, 16'hFFFF, 0, 0);
        // R12/R11: overflow history on A
        step(1, 0, 2'd1, 4'd2, 0, 16'h0000, 0, 0);   // clear A
        step(1, 0, 2'd1, 4'd1, 0, 16'h7FFF, 0, 0);
        step(1, 0, 2'd1, 4'd9, 0, 0, 0, 0);          // 0x7FFF+1 overflows
        step(1, 0, 2'd1, 4'd5, 0, 16'h8000, 0, 0);   // 0x8000+0x8000 overflows
        step(1, 0, 2'd1, 4'd8, 0, 0, 0, 0);          // 0-1, no overflow: S1/OV1 hold
        // R7/R8: carry on B feeds A
        step(1, 1, 2'd1, 4'd1, 0, 16'h8001, 0, 0);   // B = 0x8001
        step(1, 1, 2'd1, 4'd11, 0, 0, 0, 0);         // ASR keeps sign, C=1
        step(1, 0, 2'd1, 4'd7, 0, 16'h0001, 0, 0);   // ADC with cin from B
        step(1, 0, 2'd1, 4'd6, 0, 16'h0001, 0, 0);   // SBB with cin from B
        step(1, 0, 2'd1, 4'd12, 0, 0, 0, 0);         // SHL1 inserts B carry
        step(1, 0, 2'd1, 4'd7, 0, 16'hFFFF, 0, 0);   // ADC full carry out
        // R5/R10: rearranging ops on B
        step(1, 1, 2'd1, 4'd10, 0, 0, 0, 0);
        step(1, 1, 2'd1, 4'd15, 0, 0, 0, 0);
        step(1, 1, 2'd1, 4'd13, 0, 0, 0, 0);
        step(1, 1, 2'd1, 4'd14, 0, 0, 0, 0);
        step(1, 1, 2'd1, 4'd3, 0, 16'h0F0F, 0, 0);
        step(1, 1, 2'd1, 4'd4, 0, 16'h7000, 0, 0);   // R6 subtract into B

        // random traffic; R3 other accumulator compared on every step
        for (int i = 0; i < 4000; i++) begin
            step(bit'($urandom_range(0, 7) != 0), bit'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
                 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule